// File: doc/BRIEF.md
# Dual-Clock 36-bit FIFO with Fall-Through Mode

This block is a first-in first-out buffer for 36-bit words. The write port and the read port each run on their own clock, and the two clocks may be unrelated or identical. Every transfer is taken on a rising edge of its port clock, and only while that port's enable is high. Write and read pointers cross between the two clock domains as Gray code through two-stage synchronisers. Each side therefore judges the fill level from a slightly stale copy of the other side's pointer. The flags err toward "not ready": a port may briefly see less room or less data than there really is, but never more.

A static input, `fall_mode`, picks one of two behaviours. In standard mode a stored word stays in the array until a read is requested, and the read returns it on the following edge. In fall-through mode a one-word output register pulls the oldest word forward by itself, so the first word written into an empty buffer shows up on `rd_data` without any request. Each later word still needs a read.

The same two active-low flag pins serve both modes, with different meanings. In standard mode they mean empty and full. In fall-through mode they mean output-ready and input-ready. The mode input must only change while both ports are held in reset.

Top module: `xfifo36_dc`

## Requirements
- R1: Words are 36 bits wide. They leave in exactly the order in which they were accepted. The `DEPTH` parameter must be one of 256, 512 or 1024.
- R2: A port transfers nothing on an edge where its enable is low. While `wr_en` is low, `wr_data` has no effect.
- R3: A write offered while the buffer has no free place is discarded. It disturbs none of the stored words.
- R4: A read offered while no word is available leaves the read pointer and `rd_data` unchanged. A later write is then read back correctly.
- R5: In standard mode (`fall_mode`=0), a word written into an empty buffer is not placed on `rd_data`. Each accepted read updates `rd_data` on the following read-clock edge. `rd_data` holds its value on every other edge.
- R6: In fall-through mode (`fall_mode`=1), the first word written into an empty buffer appears on `rd_data` without a read. It stays there until a read consumes it. Each later word appears only after the word ahead of it has been read.
- R7: In standard mode, `rd_flag_n` is 0 exactly when no word is stored. `wr_flag_n` is 0 exactly when the buffer is full.
- R8: In fall-through mode, `rd_flag_n` is 0 exactly when a valid word is on `rd_data`. `wr_flag_n` is 0 exactly when a free place exists.
- R9: The capacity is `DEPTH` words in standard mode. In fall-through mode it is `DEPTH`+1 words, because the output register holds one word.
- R10: While either reset is low, both pointers clear and `rd_data` becomes zero. After reset, `rd_flag_n` is 0 in standard mode and 1 in fall-through mode. `wr_flag_n` is 1 in standard mode and 0 in fall-through mode.
- R11: The two clocks may be unrelated. Each pointer changes by at most one bit per edge of its own clock, and the flags stay correct when the read clock runs slower than the write clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-port clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write request, taken on rising `wr_clk` |
| wr_data | input | 36 | Word to store |
| wr_flag_n | output | 1 | Full (standard) or input-ready (fall-through), active low |
| rd_clk | input | 1 | Read-port clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Read request, taken on rising `rd_clk` |
| rd_data | output | 36 | Output word |
| rd_flag_n | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| fall_mode | input | 1 | 0 selects standard mode, 1 selects fall-through mode; static while in use |

## Verification
The hardest case to reach from the ports is the exact full boundary. It must be seen through a synchronised pointer, and in fall-through mode it includes the extra place in the output register. To get there, the bench turns the reader off and offers a burst of writes several words longer than the capacity, counting only the writes the flag allowed. It then drains the buffer and confirms that exactly the allowed count comes back, in order. A second run slows the read clock against the write clock while both ports stay busy, so the write side repeatedly meets a stale full indication and has to retry.

// File: rtl/xfifo_pkg.sv
// Shared definitions for the dual-clock 36-bit FIFO.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package xfifo_pkg;

    // Width of one stored word.
    localparam int WORD_W = 36;

    // Operating behaviour selected by the static mode input.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // True for the supported depths.
    function automatic bit depth_ok(input int d);
        return (d == 256) || (d == 512) || (d == 1024);
    endfunction

endpackage

// File: rtl/xfifo_sync.sv
// Multi-stage synchroniser for a Gray-coded pointer.
// Assumes: the input changes at most one bit per source-clock edge, so every
// sampled value is either the old or the new pointer.
module xfifo_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    // Shift the pointer through the flop chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/xfifo_ram.sv
// Simple dual-port storage array: write port on the write clock, registered
// read port on the read clock.
// Assumes: control logic never reads a location in the cycle it is written.
module xfifo_ram #(
    parameter int W     = 36,
    parameter int DEPTH = 256
) (
    input  logic                     wr_clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic                     rd_clk,
    input  logic                     rd_rst_n,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);

    logic [W-1:0] mem [DEPTH];

    // Store the incoming word on an accepted write.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Load the output register on a fetch; hold it otherwise.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/xfifo_wr_side.sv
// Write-domain control: write pointer, full detection against the
// synchronised read pointer, and the mode-dependent write flag.
// Assumes: rq_gray is already synchronised into the write clock domain.
module xfifo_wr_side
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  fifo_mode_e               mode,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH):0]   rq_gray,
    output logic                     we,
    output logic [$clog2(DEPTH)-1:0] waddr,
    output logic [$clog2(DEPTH):0]   wbin,
    output logic [$clog2(DEPTH):0]   wgray,
    output logic [$clog2(DEPTH):0]   rq_bin,
    output logic                     full,
    output logic                     flag_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin_q;
    logic [PW-1:0] wgray_q;
    logic [PW-1:0] wbin_nx;

    // Decode the synchronised Gray read pointer back to binary.
    for (genvar i = 0; i < PW; i++) begin : g_ungray
        assign rq_bin[i] = ^rq_gray[PW-1:i];
    end

    assign full    = (wbin_q - rq_bin) == PW'(DEPTH);
    assign we      = wr_en && !full;
    assign wbin_nx = wbin_q + PW'(1);

    // Advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (we) begin
            wbin_q  <= wbin_nx;
            wgray_q <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    assign waddr = wbin_q[AW-1:0];
    assign wbin  = wbin_q;
    assign wgray = wgray_q;

    // Full (low = full) in standard mode, input-ready (low = room) otherwise.
    assign flag_n = (mode == MODE_FWFT) ? full : !full;

endmodule

// File: rtl/xfifo_rd_side.sv
// Read-domain control: read pointer, empty detection against the
// synchronised write pointer, the fall-through output-register valid bit
// and the mode-dependent read flag.
// Assumes: wq_gray is already synchronised into the read clock domain.
module xfifo_rd_side
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  fifo_mode_e               mode,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH):0]   wq_gray,
    output logic                     re,
    output logic [$clog2(DEPTH)-1:0] raddr,
    output logic [$clog2(DEPTH):0]   rbin,
    output logic [$clog2(DEPTH):0]   rgray,
    output logic                     arr_empty,
    output logic                     out_valid,
    output logic                     flag_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin_q;
    logic [PW-1:0] rgray_q;
    logic [PW-1:0] rbin_nx;
    logic          ov_q;
    logic          fetch;

    assign arr_empty = (rgray_q == wq_gray);

    // Pull a word from the array on a read (standard) or whenever the
    // output register is free or being consumed (fall-through).
    always_comb begin
        if (mode == MODE_FWFT) begin
            fetch = !arr_empty && (rd_en || !ov_q);
        end else begin
            fetch = !arr_empty && rd_en;
        end
    end

    assign rbin_nx = rbin_q + PW'(1);

    // Advance the binary and Gray read pointers on a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (fetch) begin
            rbin_q  <= rbin_nx;
            rgray_q <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Track whether the output register holds an unread word (fall-through).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= 1'b0;
        end else if (mode != MODE_FWFT) begin
            ov_q <= 1'b0;
        end else if (fetch) begin
            ov_q <= 1'b1;
        end else if (rd_en) begin
            ov_q <= 1'b0;
        end
    end

    assign re        = fetch;
    assign raddr     = rbin_q[AW-1:0];
    assign rbin      = rbin_q;
    assign rgray     = rgray_q;
    assign out_valid = ov_q;

    // Empty (low = empty) in standard mode, output-ready (low = valid) otherwise.
    assign flag_n = (mode == MODE_FWFT) ? !ov_q : !arr_empty;

endmodule

// File: rtl/xfifo36_dc.sv
// Top level of the dual-clock 36-bit FIFO with selectable fall-through mode.
// Assumes: fall_mode changes only while both resets are low; each reset is
// synchronous to its own port clock.
module xfifo36_dc
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_flag_n,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_flag_n,
    input  logic              fall_mode
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    fifo_mode_e    mode;
    logic          we;
    logic          re;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wr_bin;
    logic [PW-1:0] wr_gray;
    logic [PW-1:0] rd_bin;
    logic [PW-1:0] rd_gray;
    logic [PW-1:0] rq_gray;
    logic [PW-1:0] rq_bin;
    logic [PW-1:0] wq_gray;
    logic          wr_full;
    logic          arr_empty;
    logic          out_valid;

    assign mode = fifo_mode_e'(fall_mode);

    xfifo_wr_side #(.DEPTH(DEPTH)) u_wr (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .mode    (mode),
        .wr_en   (wr_en),
        .rq_gray (rq_gray),
        .we      (we),
        .waddr   (waddr),
        .wbin    (wr_bin),
        .wgray   (wr_gray),
        .rq_bin  (rq_bin),
        .full    (wr_full),
        .flag_n  (wr_flag_n)
    );

    xfifo_rd_side #(.DEPTH(DEPTH)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .mode      (mode),
        .rd_en     (rd_en),
        .wq_gray   (wq_gray),
        .re        (re),
        .raddr     (raddr),
        .rbin      (rd_bin),
        .rgray     (rd_gray),
        .arr_empty (arr_empty),
        .out_valid (out_valid),
        .flag_n    (rd_flag_n)
    );

    xfifo_sync #(.W(PW), .STAGES(2)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_gray),
        .q     (wq_gray)
    );

    xfifo_sync #(.W(PW), .STAGES(2)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rd_gray),
        .q     (rq_gray)
    );

    xfifo_ram #(.W(WORD_W), .DEPTH(DEPTH)) u_ram (
        .wr_clk   (wr_clk),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wr_data),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .re       (re),
        .raddr    (raddr),
        .rdata    (rd_data)
    );

endmodule

// File: rtl/xfifo36_dc_chk.sv
// Property checker for the dual-clock FIFO, attached by bind.
// Assumes: observes only; drives nothing in the design.
module xfifo36_dc_chk
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input logic                   wr_clk,
    input logic                   wr_rst_n,
    input logic                   wr_en,
    input logic                   wr_full,
    input logic [$clog2(DEPTH):0] wr_bin,
    input logic [$clog2(DEPTH):0] wr_gray,
    input logic [$clog2(DEPTH):0] rq_bin,
    input logic                   rd_clk,
    input logic                   rd_rst_n,
    input logic                   rd_en,
    input logic                   arr_empty,
    input logic                   out_valid,
    input logic                   fall_mode,
    input logic [WORD_W-1:0]      rd_data,
    input logic [$clog2(DEPTH):0] rd_bin,
    input logic [$clog2(DEPTH):0] rd_gray
);

    localparam int PW = $clog2(DEPTH) + 1;

    // Only the supported depths are legal.
    initial begin
        assert_depth_legal_R1: assert (depth_ok(DEPTH))
            else $error("unsupported depth %0d", DEPTH);
    end

    // A write against a full array must not move the write pointer.
    assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_full) |=> $stable(wr_bin));

    // The write side never counts more than DEPTH words in the array.
    assert_fill_bound_R9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_bin - rq_bin) <= PW'(DEPTH));

    // The read pointer cannot move while the array looks empty.
    assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        arr_empty |=> $stable(rd_bin));

    // Standard mode: no read request, no change on the data output.
    assert_std_hold_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!fall_mode && !rd_en) |=> $stable(rd_data));

    // Fall-through mode: a presented word stays until it is read.
    assert_fwft_hold_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fall_mode && out_valid && !rd_en) |=> ($stable(rd_data) && out_valid));

    // Gray write pointer moves by at most one bit per write-clock edge.
    assert_wgray_step_R11: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // Gray read pointer moves by at most one bit per read-clock edge.
    assert_rgray_step_R11: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

endmodule

bind xfifo36_dc xfifo36_dc_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk    (wr_clk),
    .wr_rst_n  (wr_rst_n),
    .wr_en     (wr_en),
    .wr_full   (wr_full),
    .wr_bin    (wr_bin),
    .wr_gray   (wr_gray),
    .rq_bin    (rq_bin),
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .rd_en     (rd_en),
    .arr_empty (arr_empty),
    .out_valid (out_valid),
    .fall_mode (fall_mode),
    .rd_data   (rd_data),
    .rd_bin    (rd_bin),
    .rd_gray   (rd_gray)
);

// File: tb/xfifo36_dc_test.sv
`timescale 1ns/1ps
// Scoreboard bench for the dual-clock FIFO: the write driver pushes every
// accepted word into a queue; a read-side monitor pops and compares.
module xfifo36_dc_test;

    localparam int DEPTH = 256;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    real         rd_half = 4.0;
    logic        wr_rst_n = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        fall_mode = 1'b0;
    logic        wr_flag_n;
    logic        rd_flag_n;
    logic [35:0] rd_data;

    logic        reader_on = 1'b0;
    logic        force_rd = 1'b0;
    logic        pend = 1'b0;
    int          total = 0;
    int          bad = 0;
    int          drained = 0;
    int          wd_cycles = 0;
    logic [35:0] exp_q[$];

    xfifo36_dc #(.DEPTH(DEPTH)) uut (
        .wr_clk    (wr_clk),
        .wr_rst_n  (wr_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_flag_n (wr_flag_n),
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rd_flag_n (rd_flag_n),
        .fall_mode (fall_mode)
    );

    // 125 MHz write clock; read clock offset in phase, period adjustable.
    always #4 wr_clk = ~wr_clk;
    initial begin
        #1.5;
        forever #(rd_half) rd_clk = ~rd_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] word_of(input int i);
        return {4'h5, (32'(i) * 32'h9E37_79B9) ^ 32'hC0DE_0000};
    endfunction

    // Pop the next expected word and compare with the output.
    task automatic score();
        logic [35:0] e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R1", "read with nothing expected", rd_data, '0);
        end else begin
            e = exp_q.pop_front();
            drained++;
            check(rd_data === e, "R1", "word order", rd_data, e);
        end
    endtask

    // Read-side monitor: decides rd_en at each falling read edge.
    always @(negedge rd_clk) begin
        if (pend) begin
            score();
            pend = 1'b0;
        end
        if (!rd_rst_n) begin
            rd_en = 1'b0;
        end else if (reader_on && !fall_mode) begin
            rd_en = rd_flag_n;
            pend  = rd_flag_n;
        end else if (reader_on && fall_mode) begin
            if (!rd_flag_n) begin
                score();
                rd_en = 1'b1;
            end else begin
                rd_en = 1'b0;
            end
        end else begin
            rd_en = force_rd;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge wr_clk) begin
        wd_cycles++;
        if (wd_cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000", wd_cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_reset(input bit m);
        @(negedge wr_clk);
        wr_en     = 1'b0;
        reader_on = 1'b0;
        force_rd  = 1'b0;
        wr_rst_n  = 1'b0;
        rd_rst_n  = 1'b0;
        fall_mode = m;
        repeat (6) @(negedge wr_clk);
        exp_q.delete();
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
    endtask

    // Offer one word at the current falling write edge; report acceptance.
    task automatic push(input logic [35:0] w, output bit acc);
        wr_data = w;
        wr_en   = 1'b1;
        acc     = fall_mode ? !wr_flag_n : wr_flag_n;
        if (acc) exp_q.push_back(w);
        @(negedge wr_clk);
    endtask

    task automatic idle_wr();
        wr_en = 1'b0;
    endtask

    task automatic drain();
        reader_on = 1'b1;
        for (int k = 0; k < 20000 && exp_q.size() != 0; k++) @(negedge rd_clk);
        repeat (4) @(negedge rd_clk);
    endtask

    initial begin
        bit acc;
        int n;
        int base;
        bit seen;

        // ---------------- standard mode ----------------
        do_reset(1'b0);
        check(rd_flag_n == 1'b0, "R10", "std read flag after reset", 36'(rd_flag_n), 36'd0);
        check(wr_flag_n == 1'b1, "R10", "std write flag after reset", 36'(wr_flag_n), 36'd1);
        check(rd_data == '0, "R10", "data after reset", rd_data, '0);

        // R2: data toggling with wr_en low stores nothing
        for (int i = 0; i < 10; i++) begin
            wr_data = word_of(900 + i);
            @(negedge wr_clk);
        end
        repeat (8) @(negedge rd_clk);
        check(rd_flag_n == 1'b0, "R2", "idle write port leaves empty", 36'(rd_flag_n), 36'd0);

        // R5/R7: one word written, not presented until read
        push(word_of(1), acc);
        idle_wr();
        repeat (10) @(negedge rd_clk);
        check(rd_flag_n == 1'b1, "R7", "not empty after one write", 36'(rd_flag_n), 36'd1);
        check(rd_data == '0, "R5", "word not presented before read", rd_data, '0);
        drain();
        check(rd_flag_n == 1'b0, "R7", "empty after drain", 36'(rd_flag_n), 36'd0);
        check(rd_data == word_of(1), "R5", "data held after read", rd_data, word_of(1));

        // R4: reads while empty change nothing
        reader_on = 1'b0;
        @(negedge rd_clk);
        force_rd = 1'b1;
        repeat (4) @(negedge rd_clk);
        force_rd = 1'b0;
        @(negedge rd_clk);
        check(rd_data == word_of(1), "R4", "empty read keeps data", rd_data, word_of(1));
        check(rd_flag_n == 1'b0, "R4", "empty read keeps empty", 36'(rd_flag_n), 36'd0);
        @(negedge wr_clk);
        push(word_of(2), acc);
        idle_wr();
        repeat (8) @(negedge rd_clk);
        n = drained;
        drain();
        check(drained - n == 1, "R4", "one word after empty reads", 36'(drained - n), 36'd1);

        // R9/R3/R7: fill past capacity with the reader stopped
        reader_on = 1'b0;
        @(negedge wr_clk);
        n = 0;
        for (int i = 0; i < DEPTH + 4; i++) begin
            push(word_of(100 + i), acc);
            if (acc) n++;
        end
        idle_wr();
        check(n == DEPTH, "R9", "std capacity", 36'(n), 36'(DEPTH));
        check(wr_flag_n == 1'b0, "R7", "full flag low", 36'(wr_flag_n), 36'd0);
        base = drained;
        drain();
        check(drained - base == DEPTH, "R3", "overflow words discarded", 36'(drained - base), 36'(DEPTH));
        repeat (6) @(negedge wr_clk);
        check(wr_flag_n == 1'b1, "R7", "not full after drain", 36'(wr_flag_n), 36'd1);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        check(rd_flag_n == 1'b1, "R10", "fwft read flag after reset", 36'(rd_flag_n), 36'd1);
        check(wr_flag_n == 1'b0, "R10", "fwft write flag after reset", 36'(wr_flag_n), 36'd0);

        // R4: reads while not ready
        @(negedge rd_clk);
        force_rd = 1'b1;
        repeat (3) @(negedge rd_clk);
        force_rd = 1'b0;
        @(negedge rd_clk);
        check(rd_flag_n == 1'b1, "R4", "fwft read while not ready", 36'(rd_flag_n), 36'd1);

        // R6/R8: first word falls through with no read
        @(negedge wr_clk);
        push(word_of(3), acc);
        idle_wr();
        seen = 1'b0;
        for (int k = 0; k < 10 && !seen; k++) begin
            @(negedge rd_clk);
            seen = !rd_flag_n;
        end
        check(seen, "R8", "output-ready asserted", 36'(rd_flag_n), 36'd0);
        check(rd_data == word_of(3), "R6", "first word without read", rd_data, word_of(3));
        repeat (6) @(negedge rd_clk);
        check(rd_data == word_of(3) && !rd_flag_n, "R6", "word held unread", rd_data, word_of(3));
        @(negedge wr_clk);
        push(word_of(4), acc);
        idle_wr();
        repeat (8) @(negedge rd_clk);
        check(rd_data == word_of(3), "R6", "second word waits for read", rd_data, word_of(3));
        n = drained;
        drain();
        check(drained - n == 2, "R6", "two words delivered", 36'(drained - n), 36'd2);
        check(rd_flag_n == 1'b1, "R8", "not ready after drain", 36'(rd_flag_n), 36'd1);

        // R9/R8: capacity includes the output register
        reader_on = 1'b0;
        @(negedge wr_clk);
        n = 0;
        for (int i = 0; i < DEPTH + 4; i++) begin
            push(word_of(2000 + i), acc);
            if (acc) n++;
        end
        idle_wr();
        check(n == DEPTH + 1, "R9", "fwft capacity", 36'(n), 36'(DEPTH + 1));
        check(wr_flag_n == 1'b1, "R8", "input-ready deasserted", 36'(wr_flag_n), 36'd1);
        base = drained;
        drain();
        check(drained - base == DEPTH + 1, "R3", "fwft overflow discarded", 36'(drained - base), 36'(DEPTH + 1));

        // R11: slower, unrelated read clock with both ports busy
        rd_half = 7.0;
        reader_on = 1'b1;
        base = drained;
        @(negedge wr_clk);
        for (int i = 0; i < 300; i++) begin
            do push(word_of(5000 + i), acc); while (!acc);
        end
        idle_wr();
        drain();
        check(drained - base == 300, "R11", "stream across clocks", 36'(drained - base), 36'd300);
        check(rd_flag_n == 1'b1, "R11", "stream ends not ready", 36'(rd_flag_n), 36'd1);
        repeat (6) @(negedge wr_clk);
        check(wr_flag_n == 1'b0, "R11", "stream ends with room", 36'(wr_flag_n), 36'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule